// File: doc/BRIEF.md
# Boot ROM Read Overlay for a Small Memory Window

This block is a 256-byte read/write memory window with a small constant boot image laid over its lowest addresses. After reset a processor fetches its first instructions from the constant image at addresses 0 to 31. Stores to those same addresses still reach the RAM underneath. The image hides RAM only for reads and never blocks a write. This lets startup code build the RAM contents that will later take over the boot region.

The overlay turns itself off. The first read whose address has bit 5 set clears an enable flip-flop. From then on every read returns RAM, and that stays so until the next reset. At reset the flip-flop takes the value of a configuration strap, so a system can leave the overlay off entirely. Read data is registered and appears one clock after the read strobe. It holds its value until the next read.

Top module: `boot_overlay_mem`

## Requirements
- R1: After a reset with `boot_strap` high, a read at an address below 32 returns byte `addr` of the `ROM_IMAGE` parameter. Byte k sits at bits [8k+7:8k].
- R2: After a reset with `boot_strap` low, reads at every address, including those below 32, return RAM contents.
- R3: Every write stores `wr_data` into RAM at `addr`, including writes below 32 while the overlay is on. Such data becomes visible to reads once the overlay is off.
- R4: A read with address bit 5 set turns the overlay off. Every later read below 32 returns RAM.
- R5: The read that turns the overlay off returns the RAM byte at its own address.
- R6: A read at an address of 32 or more with bit 5 clear (for example 0x40 to 0x5F) returns RAM and leaves the overlay on.
- R7: `rd_data` changes only on the clock edge that samples `rd_en` high, one cycle after the strobe. Without a read it holds its value.
- R8: Once off, the overlay stays off until reset. Changing `boot_strap` outside reset has no effect.
- R9: Reset sets `rd_data` to zero. Reset does not clear RAM contents.
- R10: A read and a write to the same address in one cycle return the byte held before that write. The write still takes effect.
- R11: A write alone, even to an address with bit 5 set, neither turns the overlay off nor changes `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_strap | input | 1 | Overlay enable value loaded at reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address within the window |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench builds the block with the default 8-bit address and data and a 5-bit boot image index. It supplies its own boot image, in which every byte differs from its neighbours, so ROM and RAM sources are easy to tell apart at each low address. With these sizes the bench can cover every address of the window. That includes the 0x40 to 0x5F band, which lies outside the image but does not trip the overlay, and the bit-5 addresses above it. A random phase then repeats resets with a random strap value, so both the strap-on and strap-off paths get many reads in each state.

// File: rtl/boot_overlay_pkg.sv
package boot_overlay_pkg;

    localparam int DEF_ADDR_W = 8;
    localparam int DEF_DATA_W = 8;
    localparam int DEF_ROM_AW = 5;
    localparam int DEF_ROM_BYTES = 1 << DEF_ROM_AW;

    // Source that drives the registered read data
    typedef enum logic {
        SRC_RAM = 1'b0,
        SRC_ROM = 1'b1
    } rd_src_e;

    // Per-access decode result
    typedef struct packed {
        logic    in_window;  // address falls inside the image range
        logic    trip;       // address bit that disables the overlay
        rd_src_e src;        // selected source for this read
    } acc_dec_t;

    // Placeholder image used when no image is supplied
    function automatic logic [DEF_ROM_BYTES*DEF_DATA_W-1:0] default_image();
        logic [DEF_ROM_BYTES*DEF_DATA_W-1:0] img;
        img = '0;
        for (int k = 0; k < DEF_ROM_BYTES; k++) begin
            img[k*DEF_DATA_W +: DEF_DATA_W] = DEF_DATA_W'((k * 29 + 16'h3D) ^ (k << 3));
        end
        return img;
    endfunction

    // Decode an access against the overlay state
    function automatic acc_dec_t decode(input logic upper_zero, input logic trip_bit,
                                        input logic ovl_on);
        acc_dec_t d;
        d.in_window = upper_zero;
        d.trip      = trip_bit;
        d.src       = (ovl_on && upper_zero) ? SRC_ROM : SRC_RAM;
        return d;
    endfunction

endpackage

// File: rtl/boot_ovl_flag.sv
module boot_ovl_flag (
    input  logic clk,
    input  logic rst,
    input  logic strap,
    input  logic rd_en,
    input  logic trip,
    output logic ovl_on
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ovl_on <= strap;
        end else if (rd_en && trip) begin
            ovl_on <= 1'b0;
        end
    end
endmodule

// File: rtl/boot_ovl_ram.sv
module boot_ovl_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_q
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[addr] <= wr_data;
        end
    end

    // Read returns the byte held before a same-cycle write
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= store[addr];
        end
    end
endmodule

// File: rtl/boot_ovl_rom.sv
module boot_ovl_rom #(
    parameter int ROM_AW = 5,
    parameter int DATA_W = 8,
    localparam int BYTES = 1 << ROM_AW,
    parameter logic [BYTES*DATA_W-1:0] IMAGE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ROM_AW-1:0] idx,
    output logic [DATA_W-1:0] rd_q
);
    logic [DATA_W-1:0] table_q [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_rom_byte
        assign table_q[g] = IMAGE[g*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= table_q[idx];
        end
    end
endmodule

// File: rtl/boot_overlay_mem.sv
module boot_overlay_mem
    import boot_overlay_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int ROM_AW = DEF_ROM_AW,
    localparam int ROM_BYTES = 1 << ROM_AW,
    parameter logic [ROM_BYTES*DATA_W-1:0] ROM_IMAGE = default_image()
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_strap,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int UPPER_W = ADDR_W - ROM_AW;

    logic              ovl_on;
    logic              trip_bit;
    logic              upper_zero;
    acc_dec_t          dec;
    rd_src_e           src_q;
    logic [DATA_W-1:0] ram_q;
    logic [DATA_W-1:0] rom_q;

    assign upper_zero = (addr[ADDR_W-1:ROM_AW] == UPPER_W'(0));
    assign trip_bit   = addr[ROM_AW];
    assign dec        = decode(upper_zero, trip_bit, ovl_on);

    boot_ovl_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .strap  (boot_strap),
        .rd_en  (rd_en),
        .trip   (dec.trip),
        .ovl_on (ovl_on)
    );

    boot_ovl_ram #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_q    (ram_q)
    );

    boot_ovl_rom #(
        .ROM_AW (ROM_AW),
        .DATA_W (DATA_W),
        .IMAGE  (ROM_IMAGE)
    ) u_rom (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rd_en),
        .idx   (addr[ROM_AW-1:0]),
        .rd_q  (rom_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= SRC_RAM;
        end else if (rd_en) begin
            src_q <= dec.src;
        end
    end

    assign rd_data = (src_q == SRC_ROM) ? rom_q : ram_q;

endmodule

// File: rtl/boot_overlay_chk.sv
module boot_overlay_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              boot_strap,
    input logic              rd_en,
    input logic              trip_bit,
    input logic              ovl_on,
    input logic [DATA_W-1:0] rd_data
);
    // R9
    reset_data_chk: assert property (@(posedge clk) rst |=> (rd_data == '0));

    // R1
    reset_flag_chk: assert property (@(posedge clk) rst |=> (ovl_on == $past(boot_strap)));

    // R4
    trip_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && trip_bit) |=> !ovl_on);

    // R8
    stay_off_chk: assert property (@(posedge clk) disable iff (rst)
        !ovl_on |=> !ovl_on);

    // R6
    stay_on_chk: assert property (@(posedge clk) disable iff (rst)
        (ovl_on && !(rd_en && trip_bit)) |=> ovl_on);

    // R7
    hold_data_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
endmodule

bind boot_overlay_mem boot_overlay_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .boot_strap (boot_strap),
    .rd_en      (rd_en),
    .trip_bit   (trip_bit),
    .ovl_on     (ovl_on),
    .rd_data    (rd_data)
);

// File: tb/test_boot_overlay_mem.sv
module test_boot_overlay_mem;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int RAW = 5;
    localparam int NROM = 1 << RAW;
    localparam int NRAM = 1 << AW;

    function automatic logic [NROM*DW-1:0] tb_image();
        logic [NROM*DW-1:0] v;
        for (int k = 0; k < NROM; k++) v[k*DW +: DW] = 8'hC0 ^ 8'(k * 11);
        return v;
    endfunction
    localparam logic [NROM*DW-1:0] IMG = tb_image();

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic boot_strap = 1'b1;
    logic rd_en = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;

    boot_overlay_mem #(.ADDR_W(AW), .DATA_W(DW), .ROM_AW(RAW), .ROM_IMAGE(IMG)) i_boot_overlay_mem (
        .clk(clk), .rst(rst), .boot_strap(boot_strap), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    logic [DW-1:0] ram_m [NRAM];
    bit ovl_m;
    logic [DW-1:0] last_m;

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] expect_read(input logic [AW-1:0] a);
        if (ovl_m && a < NROM) return IMG[a*DW +: DW];
        return ram_m[a];
    endfunction

    task automatic do_reset(input bit s, input string req);
        @(negedge clk);
        rst = 1'b1; boot_strap = s; rd_en = 1'b0; wr_en = 1'b0;
        @(posedge clk); #1;
        ovl_m = s; last_m = '0;
        check(req, rd_data, '0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic access(input bit r, input bit w, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input string req);
        @(negedge clk);
        rd_en = r; wr_en = w; addr = a; wr_data = d;
        @(posedge clk); #1;
        if (r) last_m = expect_read(a);
        if (w) ram_m[a] = d;
        if (r && a[RAW]) ovl_m = 1'b0;
        check(req, rd_data, last_m);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2718));
        // R9 reset state, R1 image visible
        do_reset(1'b1, "R9");
        access(1, 0, 8'h00, 8'h00, "R1 read image byte 0");
        access(1, 0, 8'h1F, 8'h00, "R1 read image byte 31");
        // R3 fill all of RAM, including under the image
        for (int i = 0; i < NRAM; i++) access(0, 1, 8'(i), 8'($urandom), "R11 write keeps data");
        access(1, 0, 8'h07, 8'h00, "R3 image still shown after low writes");
        // R6 non-tripping read above image
        access(1, 0, 8'h40, 8'h00, "R6 read 0x40 gives RAM");
        access(1, 0, 8'h5F, 8'h00, "R6 read 0x5F gives RAM");
        access(1, 0, 8'h05, 8'h00, "R6 overlay still on");
        // R11 write to a tripping address does not disable
        access(0, 1, 8'h25, 8'h9A, "R11 write to bit5 address");
        access(1, 0, 8'h03, 8'h00, "R11 overlay still on after write");
        // R7 hold without read
        access(0, 0, 8'h00, 8'h00, "R7 idle holds data");
        // R5 / R4
        access(1, 0, 8'h20, 8'h00, "R5 tripping read gives RAM");
        access(1, 0, 8'h03, 8'h00, "R4 low read gives RAM after trip");
        access(1, 0, 8'h00, 8'h00, "R3 low write visible");
        // R8 strap change outside reset
        @(negedge clk); boot_strap = 1'b1;
        access(1, 0, 8'h01, 8'h00, "R8 strap ignored after trip");
        // R10 same-cycle read and write
        access(1, 1, 8'h11, 8'h3C, "R10 read returns old byte");
        access(1, 0, 8'h11, 8'h00, "R10 write took effect");
        // R2 strap low
        do_reset(1'b0, "R9 second reset");
        access(1, 0, 8'h02, 8'h00, "R2 RAM under strap off");
        access(1, 0, 8'h1E, 8'h00, "R2 RAM at 0x1E");
        // Random phase
        for (int blk = 0; blk < 20; blk++) begin
            do_reset(1'($urandom), "R9 random reset");
            for (int j = 0; j < 100; j++) begin
                logic [AW-1:0] a;
                a = ($urandom % 4 != 0) ? AW'($urandom % 64) : AW'($urandom);
                access(1'($urandom), 1'($urandom % 3 == 0), a, 8'($urandom), "R1 R4 R6 random");
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule